// File: doc/BRIEF.md
# Pixel Row Frame Formatter and Serializer

This block takes whole rows of latched discriminator bits from a pixel matrix and sends them off chip on a small number of serial channels. Each row word is cut into equal parts, one per channel. Every part is broken into a few slow streams, and a final interleaving stage merges those slow streams into one fast stream per channel. The bit order on a fast stream is therefore interleaved: consecutive fast bits come from different slow streams.

A frame is a run of row slots. Each accepted row strobe fills one slot, and the block counts the slots itself. Two test features help a receiver check its own synchronisation. In line-marker mode, two synthetic rows are appended after the last matrix row of each frame. In pattern-only mode, the matrix data are replaced outright by the synthetic rows. A synthetic row carries a programmable pattern in its low bits and a one-hot frame identifier in its top bits. The identifier is seeded by START and moves one place toward bit 0 on every frame.

The block also drives a data clock and one frame-sync marker. The marker is armed by a request input and has two forms: a single pulse at the end of the frame, or a copy of the data clock.

The block runs on one clock, `clk`, at twice the fast bit rate.

Top module: `pixrow_serializer`

## Requirements
- R1: A matrix row slot sends `row_data_i` with every bit whose `col_dis_i` bit is 1 forced to 0. The word is sampled in the cycle in which `row_latch_i` is accepted.
- R2: Fast stream `fast_o[c]` carries bits `[c*PART_W +: PART_W]` of the row word. At bit tick t (0 to PART_W-1) it sends the bit at offset `(t mod N_SLOW)*SEG_W + floor(t/N_SLOW)`, where `SEG_W = PART_W/N_SLOW`.
- R3: Slow stream `slow_o[c*N_SLOW+s]` sends, at bit tick t, the bit at offset `s*SEG_W + floor(t/N_SLOW)` of part c.
- R4: Timing of the data clock and bit periods:
  - A bit period is 2 clock cycles when `hs_i`=1 and `2*N_SLOW` cycles when `hs_i`=0.
  - `dclk_o` is low for the first half of each bit period and high for the second half, so the data change as `dclk_o` falls.
  - Bit 0 appears in the cycle after the accepted strobe.
  - If no new strobe arrives, all data outputs and `dclk_o` are 0 once the last bit period of the row ends.
- R5: With `line_mark_i`=1, a frame is ROWS matrix slots followed by one slot from pattern 0 and then one slot from pattern 1. With `line_mark_i`=0, a frame is ROWS slots.
- R6: A pattern slot sends `{frame_id, pattern}`, with the identifier in the top FID_W bits. With `pat_only_i`=1, matrix slot r sends pattern 0 when r is even and pattern 1 when r is odd. In that mode `row_data_i` and `col_dis_i` have no effect.
- R7: The frame identifier is `1<<(FID_W-1)` in the first frame after START and shifts right by one for each later frame. Once it reaches 0 it stays 0 until the next START.
- R8: START, or reset, does all of the following:
  - it stops serialisation, so outputs go to 0 from the next cycle;
  - it restarts slot counting at slot 0;
  - it clears marker arming.
  - A strobe that arrives in the same cycle as START is dropped.
- R9: The marker is enabled for a frame only if `speak_i` was 1 in some cycle after the previous frame start, or after START, and no later than the first slot of this frame. While `speak_i` is 0, `mark_o` is 0 in the same cycle.
- R10: When the marker is enabled:
  - with `speak_mode_i`=0, `mark_o` is 1 for the whole last bit period of the frame's last slot;
  - with `speak_mode_i`=1, `mark_o` equals `dclk_o` throughout the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the fast bit rate |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Frame restart: reseeds the identifier, idles the serializer |
| row_latch_i | input | 1 | Row strobe: fills the next slot and starts serialising it |
| row_data_i | input | ROW_W | Latched discriminator row |
| col_dis_i | input | ROW_W | Per-column disable mask |
| pat0_i | input | ROW_W-FID_W | Pattern 0 contents |
| pat1_i | input | ROW_W-FID_W | Pattern 1 contents |
| line_mark_i | input | 1 | Append two pattern slots per frame |
| pat_only_i | input | 1 | Replace matrix slots with patterns |
| hs_i | input | 1 | Fast bit rate select |
| speak_i | input | 1 | Marker request |
| speak_mode_i | input | 1 | Marker form: 0 end pulse, 1 clock copy |
| fast_o | output | N_CH | Interleaved fast streams |
| slow_o | output | N_CH*N_SLOW | Slow streams, channel-major |
| dclk_o | output | 1 | Data clock |
| mark_o | output | 1 | Frame-sync marker |

## Verification
Three pairs of events can fall in the same cycle.

- START and a row strobe. The bench drives both on the same edge and expects every output to stay idle, with no row serialised afterwards.
- The strobe that fills a frame's last slot, which also shifts the frame identifier and wraps the slot count. The bench runs line-marker frames back to back until the identifier has reached zero and stayed there, and it checks every appended row after de-scrambling the fast streams.
- The frame-start strobe that latches marker arming, and a change on `speak_i` in that cycle. The bench drops `speak_i` in the middle of a frame and compares `mark_o` against its model on every clock.

// File: rtl/pxser_pkg.sv
package pxser_pkg;

    typedef enum logic [1:0] {
        SLOT_MATRIX = 2'd0,
        SLOT_PAT0   = 2'd1,
        SLOT_PAT1   = 2'd2
    } slot_kind_e;

    // Decide what a row slot carries from its index within the frame.
    function automatic slot_kind_e pick_slot(input int unsigned idx,
                                             input int unsigned rows,
                                             input logic        pat_only);
        if (idx >= rows)
            return (idx == rows) ? SLOT_PAT0 : SLOT_PAT1;
        if (pat_only)
            return ((idx % 2) == 1) ? SLOT_PAT1 : SLOT_PAT0;
        return SLOT_MATRIX;
    endfunction

endpackage

// File: rtl/pxser_sequencer.sv
module pxser_sequencer
    import pxser_pkg::*;
#(
    parameter int ROW_W = 640,
    parameter int ROWS  = 640,
    parameter int FID_W = 10
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_i,
    input  logic                   row_latch_i,
    input  logic [ROW_W-1:0]       row_data_i,
    input  logic [ROW_W-1:0]       col_dis_i,
    input  logic [ROW_W-FID_W-1:0] pat0_i,
    input  logic [ROW_W-FID_W-1:0] pat1_i,
    input  logic                   line_mark_i,
    input  logic                   pat_only_i,
    output logic                   take_o,
    output logic                   first_o,
    output logic [ROW_W-1:0]       word_o,
    output logic                   last_o
);
    localparam int PAT_W = ROW_W - FID_W;
    localparam int RC_W  = $clog2(ROWS + 2);
    localparam logic [FID_W-1:0] FID_TOP = {1'b1, {(FID_W-1){1'b0}}};

    logic [RC_W-1:0]  rc;
    logic [FID_W-1:0] fid;
    logic [ROW_W-1:0] word_q;
    logic             last_q;
    logic [RC_W-1:0]  frame_last;
    logic             is_last;
    logic             take;
    slot_kind_e       kind;
    logic [ROW_W-1:0] nxt_word;

    assign take       = row_latch_i & ~start_i;
    assign frame_last = line_mark_i ? RC_W'(ROWS + 1) : RC_W'(ROWS - 1);
    assign is_last    = (rc >= frame_last);
    assign kind       = pick_slot(32'(rc), ROWS, pat_only_i);

    always_comb begin
        unique case (kind)
            SLOT_PAT0: nxt_word = {fid, pat0_i};
            SLOT_PAT1: nxt_word = {fid, pat1_i};
            default:   nxt_word = row_data_i & ~col_dis_i;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rc     <= '0;
            fid    <= '0;
            word_q <= '0;
            last_q <= 1'b0;
        end else if (start_i) begin
            rc  <= '0;
            fid <= FID_TOP;
        end else if (take) begin
            word_q <= nxt_word;
            last_q <= is_last;
            if (is_last) begin
                rc  <= '0;
                fid <= fid >> 1;
            end else begin
                rc <= rc + 1'b1;
            end
        end
    end

    assign take_o  = take;
    assign first_o = (rc == '0);
    assign word_o  = word_q;
    assign last_o  = last_q;

    // R7
    fid_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fid));

    // R7 R8
    fid_seed_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (fid == FID_TOP) && (rc == '0));

    // R7
    fid_zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fid == '0) && !start_i |=> (fid == '0));

    // R5
    l0_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (take && line_mark_i && rc == RC_W'(ROWS))
        |=> (word_q[PAT_W-1:0] == $past(pat0_i)));

endmodule

// File: rtl/pxser_bitclock.sv
module pxser_bitclock #(
    parameter int PART_W = 160,
    parameter int N_SLOW = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start_i,
    input  logic                      take_i,
    input  logic                      hs_i,
    output logic                      active_o,
    output logic [$clog2(PART_W)-1:0] tick_o,
    output logic                      dclk_o
);
    localparam int BIT_W = $clog2(PART_W);
    localparam int PH_W  = $clog2(2 * N_SLOW);

    logic [PH_W-1:0]  ph;
    logic [PH_W-1:0]  per_m1;
    logic [PH_W-1:0]  half;
    logic [BIT_W-1:0] t;
    logic             active;

    assign per_m1 = hs_i ? PH_W'(1) : PH_W'(2 * N_SLOW - 1);
    assign half   = hs_i ? PH_W'(1) : PH_W'(N_SLOW);

    always_ff @(posedge clk) begin
        if (rst || start_i) begin
            active <= 1'b0;
            ph     <= '0;
            t      <= '0;
        end else if (take_i) begin
            active <= 1'b1;
            ph     <= '0;
            t      <= '0;
        end else if (active) begin
            if (ph == per_m1) begin
                ph <= '0;
                if (t == BIT_W'(PART_W - 1)) begin
                    active <= 1'b0;
                    t      <= '0;
                end else begin
                    t <= t + 1'b1;
                end
            end else begin
                ph <= ph + 1'b1;
            end
        end
    end

    assign active_o = active;
    assign tick_o   = t;
    assign dclk_o   = active & (ph >= half);

    // R4
    take_low_chk: assert property (@(posedge clk) disable iff (rst)
        take_i && !start_i |=> (active_o && !dclk_o && tick_o == '0));

    // R8
    start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (!active_o && !dclk_o));

    // R4
    edge_align_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(tick_o) && active_o && !$past(take_i)) |-> $fell(dclk_o));

endmodule

// File: rtl/pxser_lane.sv
module pxser_lane #(
    parameter int PART_W = 160,
    parameter int N_SLOW = 4
) (
    input  logic [PART_W-1:0]         part_i,
    input  logic [$clog2(PART_W)-1:0] tick_i,
    input  logic                      active_i,
    output logic                      fast_o,
    output logic [N_SLOW-1:0]         slow_o
);
    localparam int BIT_W = $clog2(PART_W);
    localparam int SUB_W = $clog2(N_SLOW);
    localparam int SEG_W = PART_W / N_SLOW;

    logic [SUB_W-1:0]       sub;
    logic [BIT_W-SUB_W-1:0] k;
    logic [N_SLOW-1:0]      slow_raw;

    assign sub = tick_i[SUB_W-1:0];
    assign k   = tick_i[BIT_W-1:SUB_W];

    // One slow stream per segment: a SEG_W-to-1 selection.
    for (genvar s = 0; s < N_SLOW; s++) begin : g_slow
        assign slow_raw[s] = part_i[BIT_W'(s * SEG_W) + BIT_W'(k)];
    end

    assign slow_o = active_i ? slow_raw : '0;
    assign fast_o = active_i & slow_raw[sub];

endmodule

// File: rtl/pxser_marker.sv
module pxser_marker #(
    parameter int PART_W = 160
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start_i,
    input  logic                      take_i,
    input  logic                      first_i,
    input  logic                      speak_i,
    input  logic                      speak_mode_i,
    input  logic                      dclk_i,
    input  logic                      active_i,
    input  logic                      last_row_i,
    input  logic [$clog2(PART_W)-1:0] tick_i,
    output logic                      mark_o
);
    localparam int BIT_W = $clog2(PART_W);

    logic spk_seen;
    logic mk_en;
    logic end_bit;

    always_ff @(posedge clk) begin
        if (rst || start_i) begin
            spk_seen <= 1'b0;
            mk_en    <= 1'b0;
        end else if (take_i && first_i) begin
            mk_en    <= spk_seen;
            spk_seen <= speak_i;
        end else begin
            spk_seen <= spk_seen | speak_i;
        end
    end

    assign end_bit = active_i & last_row_i & (tick_i == BIT_W'(PART_W - 1));
    assign mark_o  = speak_i & mk_en & (speak_mode_i ? dclk_i : end_bit);

    // R9
    speak_low_chk: assert property (@(posedge clk) disable iff (rst)
        !speak_i |-> !mark_o);

    // R9
    start_unarm_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> !mark_o);

    // R10
    clock_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (speak_mode_i && mark_o) |-> dclk_i);

endmodule

// File: rtl/pixrow_serializer.sv
module pixrow_serializer #(
    parameter int ROW_W  = 640,
    parameter int N_CH   = 4,
    parameter int N_SLOW = 4,
    parameter int ROWS   = 640,
    parameter int FID_W  = 10
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_i,
    input  logic                   row_latch_i,
    input  logic [ROW_W-1:0]       row_data_i,
    input  logic [ROW_W-1:0]       col_dis_i,
    input  logic [ROW_W-FID_W-1:0] pat0_i,
    input  logic [ROW_W-FID_W-1:0] pat1_i,
    input  logic                   line_mark_i,
    input  logic                   pat_only_i,
    input  logic                   hs_i,
    input  logic                   speak_i,
    input  logic                   speak_mode_i,
    output logic [N_CH-1:0]        fast_o,
    output logic [N_CH*N_SLOW-1:0] slow_o,
    output logic                   dclk_o,
    output logic                   mark_o
);
    localparam int PART_W = ROW_W / N_CH;
    localparam int BIT_W  = $clog2(PART_W);

    logic             take;
    logic             first;
    logic [ROW_W-1:0] word;
    logic             last_row;
    logic             active;
    logic [BIT_W-1:0] tick;
    logic             dclk;

    pxser_sequencer #(
        .ROW_W(ROW_W),
        .ROWS (ROWS),
        .FID_W(FID_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .row_latch_i(row_latch_i),
        .row_data_i (row_data_i),
        .col_dis_i  (col_dis_i),
        .pat0_i     (pat0_i),
        .pat1_i     (pat1_i),
        .line_mark_i(line_mark_i),
        .pat_only_i (pat_only_i),
        .take_o     (take),
        .first_o    (first),
        .word_o     (word),
        .last_o     (last_row)
    );

    pxser_bitclock #(
        .PART_W(PART_W),
        .N_SLOW(N_SLOW)
    ) u_bclk (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .take_i  (take),
        .hs_i    (hs_i),
        .active_o(active),
        .tick_o  (tick),
        .dclk_o  (dclk)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_lane
        pxser_lane #(
            .PART_W(PART_W),
            .N_SLOW(N_SLOW)
        ) u_lane (
            .part_i  (word[c*PART_W +: PART_W]),
            .tick_i  (tick),
            .active_i(active),
            .fast_o  (fast_o[c]),
            .slow_o  (slow_o[c*N_SLOW +: N_SLOW])
        );
    end

    pxser_marker #(
        .PART_W(PART_W)
    ) u_mark (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .take_i      (take),
        .first_i     (first),
        .speak_i     (speak_i),
        .speak_mode_i(speak_mode_i),
        .dclk_i      (dclk),
        .active_i    (active),
        .last_row_i  (last_row),
        .tick_i      (tick),
        .mark_o      (mark_o)
    );

    assign dclk_o = dclk;

endmodule

// File: tb/sim_pixrow_serializer.sv
module sim_pixrow_serializer;
    localparam int RW   = 64;
    localparam int NC   = 4;
    localparam int NS   = 4;
    localparam int RS   = 3;
    localparam int FW   = 10;
    localparam int PW   = RW - FW;
    localparam int PART = RW / NC;
    localparam int SEG  = PART / NS;

    logic clk = 1'b0;
    logic rst = 1'b1, start = 1'b0, latch = 1'b0;
    logic lm = 1'b0, po = 1'b0, hs = 1'b1, spk = 1'b0, spkm = 1'b0;
    logic [RW-1:0] rdata = '0, dis = '0;
    logic [PW-1:0] p0 = '0, p1 = '0;
    wire [NC-1:0]    fast;
    wire [NC*NS-1:0] slow;
    wire             dclk, mark;

    always #10 clk = ~clk;

    pixrow_serializer #(
        .ROW_W(RW), .N_CH(NC), .N_SLOW(NS), .ROWS(RS), .FID_W(FW)
    ) u0 (
        .clk(clk), .rst(rst), .start_i(start), .row_latch_i(latch),
        .row_data_i(rdata), .col_dis_i(dis), .pat0_i(p0), .pat1_i(p1),
        .line_mark_i(lm), .pat_only_i(po), .hs_i(hs), .speak_i(spk),
        .speak_mode_i(spkm), .fast_o(fast), .slow_o(slow), .dclk_o(dclk),
        .mark_o(mark)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int   m_rc = 0, m_frame = 0, m_cnt = 0;
    bit   m_act = 0, m_last = 0, m_mken = 0, m_seen = 0, m_fidon = 0;
    logic [RW-1:0] m_word = '0, cap = '0;
    string m_tag = "R1";

    function automatic logic [FW-1:0] exp_fid();
        if (m_fidon && m_frame < FW) return FW'(1) << (FW - 1 - m_frame);
        return '0;
    endfunction

    function automatic logic [RW-1:0] exp_word(input int r);
        if (r == RS) return {exp_fid(), p0};
        if (r > RS) return {exp_fid(), p1};
        if (po) return (r % 2 == 1) ? {exp_fid(), p1} : {exp_fid(), p0};
        return rdata & ~dis;
    endfunction

    always @(posedge clk) begin
        int flen, p;
        p = hs ? 2 : 2 * NS;
        if (rst) begin
            m_act = 0; m_rc = 0; m_cnt = 0; m_mken = 0; m_seen = 0;
            m_fidon = 0; m_frame = 0; m_last = 0;
        end else if (start) begin
            m_act = 0; m_rc = 0; m_cnt = 0; m_mken = 0; m_seen = 0;
            m_fidon = 1; m_frame = 0;
        end else if (latch) begin
            flen = RS + (lm ? 2 : 0);
            if (m_rc == 0) begin
                m_mken = m_seen;
                m_seen = spk;
            end else begin
                m_seen = m_seen | spk;
            end
            m_word = exp_word(m_rc);
            if (m_rc >= RS) m_tag = (m_frame >= FW) ? "R7" : "R5";
            else if (po) m_tag = "R6";
            else m_tag = "R1";
            m_last = (m_rc >= flen - 1);
            if (m_last) begin m_rc = 0; m_frame++; end
            else m_rc++;
            m_act = 1;
            m_cnt = 0;
        end else begin
            m_seen = m_seen | spk;
            if (m_act) begin
                m_cnt++;
                if (m_cnt == PART * p) m_act = 0;
            end
        end
    end

    always @(negedge clk) begin
        int p, t, ph;
        logic [NC-1:0]    ef;
        logic [NC*NS-1:0] es;
        logic             ed, em;
        if (!rst) begin
            p = hs ? 2 : 2 * NS;
            ef = '0; es = '0; ed = 0; em = 0; t = 0; ph = 0;
            if (m_act) begin
                t  = m_cnt / p;
                ph = m_cnt % p;
                for (int c = 0; c < NC; c++) begin
                    ef[c] = m_word[c*PART + (t % NS)*SEG + t / NS];
                    for (int s = 0; s < NS; s++)
                        es[c*NS+s] = m_word[c*PART + s*SEG + t / NS];
                end
                ed = (ph >= p / 2);
                em = spk && m_mken && (spkm ? ed : (m_last && t == PART - 1));
            end
            chk({"R2/", m_tag}, RW'(fast), RW'(ef));
            chk("R3 slow", RW'(slow), RW'(es));
            chk("R4 dclk", RW'(dclk), RW'(ed));
            chk("R9/R10 marker", RW'(mark), RW'(em));
            if (m_act && ph == 0)
                for (int c = 0; c < NC; c++)
                    cap[c*PART + (t % NS)*SEG + t / NS] = fast[c];
            if (m_act && m_cnt == PART * p - 1)
                chk({"descrambled row ", m_tag}, cap, m_word);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic rows(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            latch = 1'b1;
            rdata = {$urandom(), $urandom()};
            @(negedge clk);
            latch = 1'b0;
            repeat (PART * (hs ? 2 : 2 * NS) - 2) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(2);
        // R8 reset state
        chk("R8 reset idle", RW'({fast, slow, dclk, mark}), '0);

        // R1 R2 R3 R4: matrix rows with a disable mask, fast rate
        dis = 64'hF0F0_0000_0000_00FF;
        do_start();
        rows(6);
        cyc(40);
        // R4 idle after the last row
        chk("R4 idle after row", RW'({fast, dclk}), '0);

        // R4: slow rate
        hs = 1'b0;
        do_start();
        rows(3);
        cyc(20);
        hs = 1'b1;

        // R5 R7: line-marker frames until the identifier is past zero
        lm = 1'b1;
        p0 = PW'({$urandom(), $urandom()});
        p1 = PW'({$urandom(), $urandom()});
        do_start();
        rows(5 * 13);

        // R6: pattern only, matrix data ignored
        po = 1'b1;
        dis = '1;
        do_start();
        rows(10);
        po = 1'b0;
        dis = '0;

        // R9 R10: marker end pulse, then clock copy, then speak dropped mid-frame
        spk = 1'b1;
        spkm = 1'b0;
        do_start();
        rows(10);
        spkm = 1'b1;
        rows(5);
        rows(2);
        spk = 1'b0;
        rows(8);

        // R8: START in the same cycle as a strobe
        @(negedge clk);
        start = 1'b1;
        latch = 1'b1;
        @(negedge clk);
        start = 1'b0;
        latch = 1'b0;
        cyc(20);
        chk("R8 collide dropped", RW'({fast, slow, dclk}), '0);

        // R8: START in the middle of a row
        @(negedge clk);
        latch = 1'b1;
        @(negedge clk);
        latch = 1'b0;
        cyc(7);
        do_start();
        cyc(30);
        chk("R8 start mid-row", RW'({fast, dclk, mark}), '0);

        finish_run();
    end

endmodule